// File: doc/BRIEF.md
# Destructive-Read Word Transfer Unit

This block is the memory-side datapath of a list-processing machine. It holds an address register, an input word register that is filled only from memory, an output word register that is the only source of words written to memory, and a one-bit test register fed by an equality comparator between the two word registers. The word store it fronts has a destructive read: fetching a cell leaves zero behind. A non-destructive fetch is therefore a three-step sequence: fetch into the input register, copy it across to the output register, then write it back to the same cell.

Commands arrive on a valid/ready channel. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls only during the two extra cycles of a non-destructive fetch. A command offered while `cmd_ready` is low is not taken and has no effect. An offer that stays valid until `cmd_ready` returns is taken on that edge. The four lowest cells act as fast special registers. A separate direct port reaches them with a 2-bit select, without going through the address register. When both paths hit the same special cell in the same cycle, the direct port wins.

Top module: `lmx_xfer_unit`

## Requirements
- R1: After reset the address register, both word registers and the test bit are zero, every memory cell is zero, and `cmd_ready` is high.
- R2: An accepted op code 0 (set address) loads `cur_addr` from `cmd_addr` at that edge.
- R3: An accepted op code 1 (destructive fetch) loads `r_in` from the cell at `cur_addr` and clears that cell at the same edge.
- R4: An accepted op code 2 (non-destructive fetch) loads `r_in` from the cell and clears it at the accept edge. At the next edge `r_out` takes `r_in`. At the edge after that the cell is rewritten with `r_out`, so the cell ends with its original value and `r_out` equals `r_in`.
- R5: After an op code 2 is accepted, `cmd_ready` is low for exactly the next two cycles. Commands offered in those cycles are not taken and change nothing.
- R6: An accepted op code 3 (store) writes `r_out` into the cell at `cur_addr`.
- R7: An accepted op code 4 (compare) sets `test_bit` to 1 if `r_in` equals `r_out` and to 0 otherwise. `test_bit` keeps its value at every other edge.
- R8: An accepted op code 5 (copy) loads `r_out` from `r_in`. `r_out` changes only through op codes 5 and 2, and `r_in` changes only through op codes 1 and 2.
- R9: Accepted op codes 6 and 7 change no register and no cell.
- R10: `dir_rdata` always shows the special cell (addresses 0 to 3) selected by `dir_sel`, without clearing it. `dir_we` writes `dir_wdata` into that cell at the edge.
- R11: When a direct write and an address-register write or destructive fetch hit the same special cell in the same cycle, the cell takes `dir_wdata`. A fetch in that cycle still loads the old cell value into `r_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Op code: 0 set address, 1 destructive fetch, 2 non-destructive fetch, 3 store, 4 compare, 5 copy |
| cmd_addr | input | 8 | Address for op code 0 |
| dir_we | input | 1 | Direct write strobe |
| dir_sel | input | 2 | Special cell select for the direct port |
| dir_wdata | input | 32 | Direct write word |
| dir_rdata | output | 32 | Contents of the selected special cell |
| cur_addr | output | 8 | Address register |
| r_in | output | 32 | Input word register |
| r_out | output | 32 | Output word register |
| test_bit | output | 1 | Result of the last compare |

## Verification
A direct-port write and an address-register access can land on the same special cell in one cycle. The bench creates this twice. First it points the address register at cell 0 and issues a store in the same cycle as a direct write to cell 0. Then it issues a destructive fetch from cell 0 in the same cycle as a second direct write to it. In both cases the bench reads the cell back through the direct port and expects the direct value. In the fetch case it also expects `r_in` to hold the cell's earlier contents. A second overlap is a command offered while a non-destructive fetch is still running. The bench checks that such a command is dropped and that the address register and the restored cell are untouched.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
  typedef enum logic [2:0] {
    OP_SETA = 3'd0,
    OP_RDD  = 3'd1,
    OP_RDN  = 3'd2,
    OP_WR   = 3'd3,
    OP_CMP  = 3'd4,
    OP_CPY  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHUNT = 2'd1,
    ST_WBACK = 2'd2
  } seq_e;
endpackage

// File: rtl/lmx_word_store.sv
module lmx_word_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 256,
  parameter int NSPEC  = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SEL_W  = $clog2(NSPEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_rd,
  input  logic              a_we,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic              d_we,
  input  logic [SEL_W-1:0]  d_sel,
  input  logic [WORD_W-1:0] d_wdata,
  output logic [WORD_W-1:0] d_rdata
);
  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [WORD_W-1:0] q;
    logic              hit_a;
    assign hit_a    = (a_addr == ADDR_W'(i));
    assign cells[i] = q;
    if (i < NSPEC) begin : g_spec
      // special cell: direct port has priority over the address path
      logic hit_d;
      assign hit_d = d_we && (d_sel == SEL_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)               q <= '0;
        else if (hit_d)           q <= d_wdata;
        else if (a_we && hit_a)   q <= a_wdata;
        else if (a_rd && hit_a)   q <= '0;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)               q <= '0;
        else if (a_we && hit_a)   q <= a_wdata;
        else if (a_rd && hit_a)   q <= '0;
      end
    end
  end

  assign a_rdata = cells[a_addr];
  assign d_rdata = cells[ADDR_W'(d_sel)];
endmodule

// File: rtl/lmx_xfer_seq.sv
module lmx_xfer_seq
  import lmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       cmd_ready,
  output logic       s_seta,
  output logic       s_rd,
  output logic       s_cp,
  output logic       s_wr,
  output logic       s_cmp
);
  seq_e st_q, st_d;
  logic acc;

  assign cmd_ready = (st_q == ST_IDLE);
  assign acc       = cmd_valid && cmd_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (acc && cmd_op == OP_RDN) st_d = ST_SHUNT;
      ST_SHUNT: st_d = ST_WBACK;
      ST_WBACK: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign s_seta = acc && (cmd_op == OP_SETA);
  assign s_rd   = acc && (cmd_op == OP_RDD || cmd_op == OP_RDN);
  assign s_cp   = (acc && cmd_op == OP_CPY) || (st_q == ST_SHUNT);
  assign s_wr   = (acc && cmd_op == OP_WR)  || (st_q == ST_WBACK);
  assign s_cmp  = acc && (cmd_op == OP_CMP);
endmodule

// File: rtl/lmx_test_cmp.sv
module lmx_test_cmp #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  output logic              flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)  flag <= 1'b0;
    else if (en) flag <= (lhs == rhs);
  end
endmodule

// File: rtl/lmx_xfer_unit.sv
module lmx_xfer_unit #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 256,
  parameter int NSPEC  = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SEL_W  = $clog2(NSPEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              dir_we,
  input  logic [SEL_W-1:0]  dir_sel,
  input  logic [WORD_W-1:0] dir_wdata,
  output logic [WORD_W-1:0] dir_rdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [WORD_W-1:0] r_in,
  output logic [WORD_W-1:0] r_out,
  output logic              test_bit
);
  logic s_seta, s_rd, s_cp, s_wr, s_cmp;
  logic [WORD_W-1:0] mem_rdata;

  lmx_xfer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .s_seta(s_seta), .s_rd(s_rd), .s_cp(s_cp),
    .s_wr(s_wr), .s_cmp(s_cmp)
  );

  lmx_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .NSPEC(NSPEC)) u_store (
    .clk(clk), .rst_n(rst_n), .a_addr(cur_addr), .a_rd(s_rd), .a_we(s_wr),
    .a_wdata(r_out), .a_rdata(mem_rdata), .d_we(dir_we), .d_sel(dir_sel),
    .d_wdata(dir_wdata), .d_rdata(dir_rdata)
  );

  lmx_test_cmp #(.WORD_W(WORD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(s_cmp), .lhs(r_in), .rhs(r_out),
    .flag(test_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      r_in     <= '0;
      r_out    <= '0;
    end else begin
      if (s_seta) cur_addr <= cmd_addr;
      if (s_rd)   r_in     <= mem_rdata;
      if (s_cp)   r_out    <= r_in;
    end
  end
endmodule

// File: rtl/lmx_xfer_chk.sv
module lmx_xfer_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              dir_we,
  input logic [SEL_W-1:0]  dir_sel,
  input logic [WORD_W-1:0] dir_wdata,
  input logic [WORD_W-1:0] dir_rdata,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [WORD_W-1:0] r_in,
  input logic [WORD_W-1:0] r_out,
  input logic              test_bit
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R2
  seta_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd0) |=> (cur_addr == $past(cmd_addr)));
  // R4
  rdn_shunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd2) |=> ##1 (r_out == r_in));
  // R5
  rdn_busy1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd2) |=> !cmd_ready);
  // R5
  rdn_busy2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd2) |=> ##1 !cmd_ready);
  // R5
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(cur_addr));
  // R7
  cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd4) |=> (test_bit == ($past(r_in) == $past(r_out))));
  // R7
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && cmd_op == 3'd4) |=> $stable(test_bit));
  // R8
  copy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5) |=> (r_out == $past(r_in)));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !(acc && (cmd_op == 3'd5 || cmd_op == 3'd2))) |=> $stable(r_out));
  // R8
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && (cmd_op == 3'd1 || cmd_op == 3'd2)) |=> $stable(r_in));
  // R9
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op >= 3'd6) |=>
      ($stable(r_in) && $stable(r_out) && $stable(test_bit) && $stable(cur_addr)));
  // R11
  dir_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dir_we) && dir_sel == $past(dir_sel))
      |-> (dir_rdata == $past(dir_wdata)));
endmodule

bind lmx_xfer_unit lmx_xfer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .dir_we(dir_we), .dir_sel(dir_sel),
  .dir_wdata(dir_wdata), .dir_rdata(dir_rdata), .cur_addr(cur_addr),
  .r_in(r_in), .r_out(r_out), .test_bit(test_bit)
);

// File: tb/lmx_xfer_unit_test.sv
`timescale 1ns/100ps
module lmx_xfer_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_addr = 8'd0;
  logic        dir_we = 1'b0;
  logic [1:0]  dir_sel = 2'd0;
  logic [31:0] dir_wdata = 32'd0;
  logic [31:0] dir_rdata;
  logic [7:0]  cur_addr;
  logic [31:0] r_in, r_out;
  logic        test_bit;

  always #2.5 clk = ~clk;

  lmx_xfer_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .dir_we(dir_we), .dir_sel(dir_sel),
    .dir_wdata(dir_wdata), .dir_rdata(dir_rdata), .cur_addr(cur_addr),
    .r_in(r_in), .r_out(r_out), .test_bit(test_bit)
  );

  // kinds: 0 r_in, 1 r_out, 2 test_bit, 3 dir_rdata, 4 cmd_ready, 5 cur_addr
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic peek(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    dir_sel = sel;
    #1;
    expect_item(3, exp, tag);
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb.size() > 0);
      it = sb.pop_front();
      case (it.kind)
        0: act = r_in;
        1: act = r_out;
        2: act = {31'd0, test_bit};
        3: act = dir_rdata;
        4: act = {31'd0, cmd_ready};
        default: act = {24'd0, cur_addr};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [7:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic dwrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    dir_we = 1'b1; dir_sel = sel; dir_wdata = d;
    @(negedge clk);
    dir_we = 1'b0;
  endtask

  task automatic both(input logic [2:0] op, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    dir_we = 1'b1; dir_sel = sel; dir_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; dir_we = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_item(0, 32'd0, "R1 r_in");
    expect_item(1, 32'd0, "R1 r_out");
    expect_item(2, 32'd0, "R1 test_bit");
    expect_item(4, 32'd1, "R1 cmd_ready");
    expect_item(5, 32'd0, "R1 cur_addr");
    peek(2'd3, 32'd0, "R1 cell3");

    // R10 direct write and read
    dwrite(2'd1, 32'hA5A5_0001);
    peek(2'd1, 32'hA5A5_0001, "R10 direct cell1");
    peek(2'd1, 32'hA5A5_0001, "R10 direct read keeps cell");

    // R2 set address
    cmd(3'd0, 8'd1);
    expect_item(5, 32'd1, "R2 cur_addr");

    // R3 destructive fetch
    cmd(3'd1, 8'd0);
    expect_item(0, 32'hA5A5_0001, "R3 r_in loaded");
    peek(2'd1, 32'd0, "R3 cell cleared");
    cmd(3'd1, 8'd0);
    expect_item(0, 32'd0, "R3 second fetch zero");

    // R4 / R5 non-destructive fetch with offer while busy
    dwrite(2'd2, 32'h1234_5678);
    cmd(3'd0, 8'd2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2;
    @(negedge clk);
    expect_item(4, 32'd0, "R5 busy first");
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 8'h55;
    @(negedge clk);
    cmd_valid = 1'b0;
    expect_item(4, 32'd0, "R5 busy second");
    @(negedge clk);
    expect_item(4, 32'd1, "R5 ready again");
    expect_item(5, 32'd2, "R5 busy offer dropped");
    expect_item(0, 32'h1234_5678, "R4 r_in");
    expect_item(1, 32'h1234_5678, "R4 r_out");
    peek(2'd2, 32'h1234_5678, "R4 cell restored");

    // R6 store to a plain cell, read back
    cmd(3'd0, 8'd1);
    cmd(3'd1, 8'd0);
    expect_item(0, 32'd0, "R6 r_in cleared by fetch of empty cell");
    cmd(3'd0, 8'h80);
    cmd(3'd3, 8'd0);
    cmd(3'd1, 8'd0);
    expect_item(0, 32'h1234_5678, "R6 stored word fetched");
    cmd(3'd1, 8'd0);
    expect_item(0, 32'd0, "R3 plain cell cleared");

    // R7 compare, R8 copy
    cmd(3'd4, 8'd0);
    expect_item(2, 32'd0, "R7 unequal");
    cmd(3'd5, 8'd0);
    expect_item(1, 32'd0, "R8 copy");
    cmd(3'd4, 8'd0);
    expect_item(2, 32'd1, "R7 equal");
    dwrite(2'd3, 32'hDEAD_BEEF);
    cmd(3'd0, 8'd3);
    cmd(3'd1, 8'd0);
    expect_item(0, 32'hDEAD_BEEF, "R3 fetch special");
    expect_item(2, 32'd1, "R7 test holds");
    expect_item(1, 32'd0, "R8 r_out holds on fetch");
    cmd(3'd4, 8'd0);
    expect_item(2, 32'd0, "R7 unequal again");

    // R9 undefined op codes
    cmd(3'd6, 8'd9);
    cmd(3'd7, 8'd9);
    expect_item(0, 32'hDEAD_BEEF, "R9 r_in");
    expect_item(1, 32'd0, "R9 r_out");
    expect_item(2, 32'd0, "R9 test_bit");
    expect_item(5, 32'd3, "R9 cur_addr");

    // R11 direct write wins over store and over fetch
    cmd(3'd5, 8'd0);
    expect_item(1, 32'hDEAD_BEEF, "R8 copy special word");
    cmd(3'd0, 8'd0);
    both(3'd3, 2'd0, 32'h0BAD_F00D);
    peek(2'd0, 32'h0BAD_F00D, "R11 direct beats store");
    both(3'd1, 2'd0, 32'h1111_1111);
    expect_item(0, 32'h0BAD_F00D, "R11 fetch sees old word");
    peek(2'd0, 32'h1111_1111, "R11 direct beats clear");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule